// File: doc/BRIEF.md
# Vector length configuration unit

This block runs one set-vector-length operation each time its valid strobe is high. It works out a new maximum vector length (MVL) and a new current vector length (VL), and writes both into a 64-bit vector state register that it holds. It can also write VL to a destination register and produce a 4-bit condition field. The operands come from the issue stage already decoded: a 7-bit immediate, three mode bits (set-MVL, set-VL, vertical-first), a record flag, the indices of the source and destination registers, the value of the source register, and the value of the count register.

The source of VL depends on whether the two register indices are zero. VL can come from the source register operand, from the count register, from the immediate, or from the VL already held in the state. Values from the source register or the count register that do not fit in 7 bits saturate to 127. Every result is then clamped to MVL. Both the saturation and the clamp raise an overflow indication, and that overflow goes into the condition field. The condition field is computed from VL, not from the destination register, so it is written even when no destination register is named.

The state register updates at the clock edge where valid is high. The write strobes and the result data appear on the outputs for the cycle that follows that edge.

Top module: `vlen_cfg_unit`

## Requirements
- R1: After an asynchronous reset, `state_o` is zero and `rd_we_o`, `cr_we_o`, `rd_data_o` and `cr_o` are all zero.
- R2: The effective immediate is `imm_i + 1`, kept to 7 bits, so an immediate of 127 gives 0. When `ms_i=1`, the MVL field `state_o[63:57]` takes the effective immediate. When `ms_i=0`, the MVL field keeps its value.
- R3: When `vs_i=0`, the candidate VL is the VL field already held in `state_o[56:50]`.
- R4: When `vs_i=1` and `ra_idx_i!=0`, the candidate VL is `ra_val_i` if that value is at most 127. If it is larger, the candidate VL is 127 and overflow is raised.
- R5: When `vs_i=1`, `ra_idx_i=0` and `rt_idx_i=0`, the candidate VL is the effective immediate.
- R6: When `vs_i=1`, `ra_idx_i=0` and `rt_idx_i!=0`, the candidate VL is `ctr_val_i` if that value is at most 127. If it is larger, the candidate VL is 127 and overflow is raised.
- R7: If the candidate VL is greater than the new MVL (unsigned compare), the final VL is MVL and overflow is raised. The final VL is written to `state_o[56:50]`. The VL field therefore never exceeds the MVL field.
- R8: When `rt_idx_i!=0`, `rd_we_o` pulses for one cycle and `rd_data_o` holds the final VL zero-extended to 64 bits. When `rt_idx_i=0`, there is no write.
- R9: When `ms_i=1`, `state_o[0]` (vertical-first) takes `vf_i` and `state_o[1]` (persist) is cleared. When `ms_i=0`, both bits keep their values. No operation changes any other state bit.
- R10: `cr_we_o` pulses only when `rc_i=1`. `cr_o` holds {LT,GT,EQ,SO} with LT in bit 3, where LT=0, GT=(VL!=0), EQ=(VL==0) and SO=overflow.
- R11: A cycle with `valid_i=0` leaves `state_o` unchanged, and in the next cycle `rd_we_o` and `cr_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| imm_i | input | 7 | Immediate, encoded as length minus one |
| ms_i | input | 1 | Set MVL from the immediate |
| vs_i | input | 1 | Set VL |
| vf_i | input | 1 | Vertical-first value, applied only with ms_i |
| rc_i | input | 1 | Write the condition field |
| ra_idx_i | input | 5 | Source register index |
| rt_idx_i | input | 5 | Destination register index |
| ra_val_i | input | 64 | Source register value |
| ctr_val_i | input | 64 | Count register value |
| state_o | output | 64 | Vector state register |
| rd_we_o | output | 1 | Destination write enable |
| rd_data_o | output | 64 | Destination write data |
| cr_we_o | output | 1 | Condition field write enable |
| cr_o | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
A source select that picks the wrong input shows up in the VL field of `state_o` in the cycle right after the strobe. When a destination register is named, the same wrong value also appears on `rd_data_o`. A broken saturation or clamp shows up in that same cycle in two ways: the VL field is larger than the MVL field, or the SO flag disagrees with the value that was finally chosen. A state register that drifts while the strobe is low, or that loses the held MVL or VL, is caught by the next operation in the sweep, because that operation reads the held fields back as its hold-mode source.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned LEN_W  = 7;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned CR_W   = 4;
  // state field positions, LSB-0
  localparam int unsigned MVL_LO = XLEN - LEN_W;
  localparam int unsigned VL_LO  = MVL_LO - LEN_W;
  localparam int unsigned VF_BIT = 0;
  localparam int unsigned PS_BIT = 1;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_t;
endpackage

// File: rtl/vl_sat.sv
module vl_sat #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = 7
) (
  input  logic [XLEN-1:0]  val_i,
  output logic [LEN_W-1:0] len_o,
  output logic             ovf_o
);
  always_comb begin
    ovf_o = |val_i[XLEN-1:LEN_W];
    len_o = ovf_o ? {LEN_W{1'b1}} : val_i[LEN_W-1:0];
  end
endmodule

// File: rtl/vl_src_sel.sv
module vl_src_sel #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = 7
) (
  input  logic             vs_i,
  input  logic             ra_nz_i,
  input  logic             rt_nz_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [XLEN-1:0]  ctr_val_i,
  input  logic [LEN_W-1:0] imm_eff_i,
  input  logic [LEN_W-1:0] held_vl_i,
  output logic [LEN_W-1:0] vl_o,
  output logic             ovf_o
);
  localparam int unsigned NSAT = 2;  // 0: register operand, 1: count register

  logic [XLEN-1:0]  sat_in  [NSAT];
  logic [LEN_W-1:0] sat_len [NSAT];
  logic [NSAT-1:0]  sat_ovf;

  assign sat_in[0] = ra_val_i;
  assign sat_in[1] = ctr_val_i;

  for (genvar s = 0; s < NSAT; s++) begin : g_sat
    vl_sat #(.XLEN(XLEN), .LEN_W(LEN_W)) u_sat (
      .val_i (sat_in[s]),
      .len_o (sat_len[s]),
      .ovf_o (sat_ovf[s])
    );
  end

  always_comb begin
    vl_o  = held_vl_i;
    ovf_o = 1'b0;
    if (vs_i) begin
      if (ra_nz_i) begin
        vl_o  = sat_len[0];
        ovf_o = sat_ovf[0];
      end else if (rt_nz_i) begin
        vl_o  = sat_len[1];
        ovf_o = sat_ovf[1];
      end else begin
        vl_o  = imm_eff_i;
      end
    end
  end
endmodule

// File: rtl/vl_clamp.sv
module vl_clamp #(
  parameter int unsigned LEN_W = 7
) (
  input  logic [LEN_W-1:0] vl_i,
  input  logic [LEN_W-1:0] mvl_i,
  output logic [LEN_W-1:0] vl_o,
  output logic             ovf_o
);
  always_comb begin
    ovf_o = vl_i > mvl_i;
    vl_o  = ovf_o ? mvl_i : vl_i;
  end
endmodule

// File: rtl/vl_cr_gen.sv
module vl_cr_gen
  import vlcfg_pkg::*;
#(
  parameter int unsigned LEN_W = 7
) (
  input  logic [LEN_W-1:0] vl_i,
  input  logic             ovf_i,
  output cr_t              cr_o
);
  always_comb begin
    cr_o.lt = 1'b0;
    cr_o.eq = ~|vl_i;
    cr_o.gt = |vl_i;
    cr_o.so = ovf_i;
  end
endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit
  import vlcfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] imm_i,
  input  logic             ms_i,
  input  logic             vs_i,
  input  logic             vf_i,
  input  logic             rc_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [IDX_W-1:0] rt_idx_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [XLEN-1:0]  ctr_val_i,
  output logic [XLEN-1:0]  state_o,
  output logic             rd_we_o,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             cr_we_o,
  output logic [CR_W-1:0]  cr_o
);
  logic [XLEN-1:0]  state_q, state_d;
  logic [LEN_W-1:0] imm_eff, mvl_new, held_mvl, held_vl;
  logic [LEN_W-1:0] vl_cand, vl_fin;
  logic             src_ovf, clamp_ovf;
  logic             ra_nz, rt_nz;
  cr_t              cr_new;

  assign held_mvl = state_q[MVL_LO +: LEN_W];
  assign held_vl  = state_q[VL_LO  +: LEN_W];
  assign imm_eff  = imm_i + LEN_W'(1);
  assign mvl_new  = ms_i ? imm_eff : held_mvl;
  assign ra_nz    = |ra_idx_i;
  assign rt_nz    = |rt_idx_i;

  vl_src_sel #(.XLEN(XLEN), .LEN_W(LEN_W)) u_src (
    .vs_i      (vs_i),
    .ra_nz_i   (ra_nz),
    .rt_nz_i   (rt_nz),
    .ra_val_i  (ra_val_i),
    .ctr_val_i (ctr_val_i),
    .imm_eff_i (imm_eff),
    .held_vl_i (held_vl),
    .vl_o      (vl_cand),
    .ovf_o     (src_ovf)
  );

  vl_clamp #(.LEN_W(LEN_W)) u_clamp (
    .vl_i  (vl_cand),
    .mvl_i (mvl_new),
    .vl_o  (vl_fin),
    .ovf_o (clamp_ovf)
  );

  vl_cr_gen #(.LEN_W(LEN_W)) u_cr (
    .vl_i  (vl_fin),
    .ovf_i (src_ovf | clamp_ovf),
    .cr_o  (cr_new)
  );

  always_comb begin
    state_d = state_q;
    state_d[MVL_LO +: LEN_W] = mvl_new;
    state_d[VL_LO  +: LEN_W] = vl_fin;
    if (ms_i) begin
      state_d[VF_BIT] = vf_i;
      state_d[PS_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= '0;
      rd_we_o   <= 1'b0;
      rd_data_o <= '0;
      cr_we_o   <= 1'b0;
      cr_o      <= '0;
    end else begin
      rd_we_o <= valid_i & rt_nz;
      cr_we_o <= valid_i & rc_i;
      if (valid_i) begin
        state_q   <= state_d;
        rd_data_o <= {{(XLEN-LEN_W){1'b0}}, vl_fin};
        cr_o      <= cr_new;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/vlen_cfg_chk.sv
module vlen_cfg_chk
  import vlcfg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ms_i,
  input logic [IDX_W-1:0] rt_idx_i,
  input logic [XLEN-1:0]  state_o,
  input logic             rd_we_o,
  input logic [XLEN-1:0]  rd_data_o,
  input logic             cr_we_o,
  input logic [CR_W-1:0]  cr_o
);
  logic [LEN_W-1:0] mvl_f, vl_f;
  assign mvl_f = state_o[MVL_LO +: LEN_W];
  assign vl_f  = state_o[VL_LO  +: LEN_W];

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(state_o) && !rd_we_o && !cr_we_o));

  a_r7_vl_within_mvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_f <= mvl_f);

  a_r2_mvl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ms_i) |=> (state_o[MVL_LO +: LEN_W] == $past(state_o[MVL_LO +: LEN_W])));

  a_r9_mode_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ms_i) |=> (state_o[PS_BIT:VF_BIT] == $past(state_o[PS_BIT:VF_BIT])));

  a_r9_persist_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ms_i) |=> !state_o[PS_BIT]);

  a_r8_rd_matches_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_data_o == {{(XLEN-LEN_W){1'b0}}, vl_f}));

  a_r8_no_rd_rt0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rt_idx_i == '0) |=> !rd_we_o);

  a_r10_cr_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (!cr_o[3] && (cr_o[1] == (vl_f == '0)) && (cr_o[2] == (vl_f != '0))));
endmodule

bind vlen_cfg_unit vlen_cfg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .ms_i      (ms_i),
  .rt_idx_i  (rt_idx_i),
  .state_o   (state_o),
  .rd_we_o   (rd_we_o),
  .rd_data_o (rd_data_o),
  .cr_we_o   (cr_we_o),
  .cr_o      (cr_o)
);

// File: tb/sim_vlen_cfg_unit.sv
`timescale 1ns/1ps
module sim_vlen_cfg_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [6:0]  imm_i = '0;
  logic        ms_i = 1'b0, vs_i = 1'b0, vf_i = 1'b0, rc_i = 1'b0;
  logic [4:0]  ra_idx_i = '0, rt_idx_i = '0;
  logic [63:0] ra_val_i = '0, ctr_val_i = '0;
  logic [63:0] state_o, rd_data_o;
  logic        rd_we_o, cr_we_o;
  logic [3:0]  cr_o;

  int checks = 0;
  int fails = 0;
  logic [63:0] m_state = '0;

  always #5 clk_i = ~clk_i;

  vlen_cfg_unit u0 (
    .clk_i, .rst_ni, .valid_i, .imm_i, .ms_i, .vs_i, .vf_i, .rc_i,
    .ra_idx_i, .rt_idx_i, .ra_val_i, .ctr_val_i,
    .state_o, .rd_we_o, .rd_data_o, .cr_we_o, .cr_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic run_op(input logic ms, input logic vs, input logic vf, input logic rc,
                        input logic [4:0] ra, input logic [4:0] rt, input logic [6:0] imm,
                        input logic [63:0] rav, input logic [63:0] ctr);
    int eff, mvl, vl, ovf;
    string vreq;
    logic [63:0] exp_st;
    eff = (int'(imm) + 1) % 128;
    mvl = ms ? eff : int'(m_state[63:57]);
    ovf = 0;
    if (!vs) begin vl = int'(m_state[56:50]); vreq = "R3"; end
    else if (ra != 0) begin
      vreq = "R4";
      if (rav > 64'd127) begin vl = 127; ovf = 1; end else vl = int'(rav);
    end else if (rt == 0) begin vl = eff; vreq = "R5"; end
    else begin
      vreq = "R6";
      if (ctr > 64'd127) begin vl = 127; ovf = 1; end else vl = int'(ctr);
    end
    if (vl > mvl) begin vl = mvl; ovf = 1; vreq = "R7"; end
    exp_st = m_state;
    exp_st[63:57] = 7'(mvl);
    exp_st[56:50] = 7'(vl);
    if (ms) begin exp_st[0] = vf; exp_st[1] = 1'b0; end

    @(negedge clk_i);
    valid_i = 1'b1; ms_i = ms; vs_i = vs; vf_i = vf; rc_i = rc;
    ra_idx_i = ra; rt_idx_i = rt; imm_i = imm; ra_val_i = rav; ctr_val_i = ctr;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R2 mvl field", 64'(state_o[63:57]), 64'(mvl));
    chk({vreq, " vl field"}, 64'(state_o[56:50]), 64'(vl));
    chk("R9 mode bits", state_o, exp_st);
    chk("R8 rd we", 64'(rd_we_o), 64'(rt != 0));
    if (rt != 0) chk("R8 rd data", rd_data_o, 64'(vl));
    chk("R10 cr we", 64'(cr_we_o), 64'(rc));
    if (rc) chk("R10 cr value", 64'(cr_o), 64'({1'b0, vl != 0, vl == 0, ovf != 0}));
    m_state = exp_st;
    // idle cycle with scrambled operands
    ms_i = ~ms; vs_i = ~vs; rt_idx_i = 5'd9; rc_i = 1'b1; imm_i = ~imm;
    @(negedge clk_i);
    chk("R11 idle state", state_o, m_state);
    chk("R11 idle strobes", 64'({rd_we_o, cr_we_o}), 64'd0);
  endtask

  initial begin
    logic [6:0]  imms [5] = '{7'd0, 7'd3, 7'd7, 7'd126, 7'd127};
    logic [63:0] ravs [5] = '{64'd0, 64'd5, 64'd127, 64'd128, 64'hFFFF_FFFF_FFFF_FFFF};
    logic [63:0] ctrs [4] = '{64'd0, 64'd9, 64'd127, 64'd200};
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", state_o, 64'd0);
    chk("R1 reset strobes", 64'({rd_we_o, cr_we_o, cr_o}), 64'd0);
    chk("R1 reset rd data", rd_data_o, 64'd0);
    rst_ni = 1'b1;
    for (int ms = 0; ms < 2; ms++)
      for (int vs = 0; vs < 2; vs++)
        for (int vf = 0; vf < 2; vf++)
          for (int rc = 0; rc < 2; rc++)
            for (int ra = 0; ra < 2; ra++)
              for (int rt = 0; rt < 2; rt++)
                for (int i = 0; i < 5; i++)
                  for (int j = 0; j < 5; j++)
                    for (int k = 0; k < 4; k++)
                      run_op(ms[0], vs[0], vf[0], rc[0], ra[0] ? 5'd3 : 5'd0,
                             rt[0] ? 5'd7 : 5'd0, imms[i], ravs[j], ctrs[k]);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule